// File: doc/BRIEF.md
# Single-Clock Dual-Port RAM with Write-Collision Arbitration

This block is a synchronous memory with two symmetric ports, A and B, on one clock. Each port can read or write any word in any cycle. Read data is registered, so it appears on the port one cycle after the access is presented. When both ports write the same word in the same cycle, a comparator detects the clash and cancels one of the two writes. A static configuration input picks which port gives way, so neither port is built in as the stronger one. The chosen port's write is dropped and the other port's write completes.

Each port has its own read-during-write setting. In old-data mode, a read of a word that is being written in that cycle returns the content from before the write. In new-data mode, the read returns the content the word holds after the cycle. A forwarding path supplies that value from whichever port actually wrote it. The rules are the same for a port's own write and for a write made by the other port.

The storage array has no reset and no initial values. Reset clears only the read registers and the collision flag.

Top module: `twinport_ram`

## Requirements
- R1: An enabled access (`*_en`=1) at an address that no port writes in that cycle returns that address's stored word on `*_rdata` on the next clock edge.
- R2: When both ports write the same address in one cycle, exactly one of the two writes changes the memory.
- R3: With `cfg_block_b`=1, port B's write is dropped on a collision and port A's data is stored. With `cfg_block_b`=0, port A's write is dropped and port B's data is stored.
- R4: `collide` is 1 in the cycle after a same-address write by both ports and 0 after any other cycle.
- R5: When both ports write different addresses in one cycle, both words are updated by that same clock edge.
- R6: With `*_mode`=0 (old data), a read of an address that either port writes in the same cycle returns the content from before that write.
- R7: With `*_mode`=1 (new data), a read of an address that is written in the same cycle returns the data the winning write stores there, whether that write came from this port or the other.
- R8: A port with `*_en`=0 neither writes, even if `*_we`=1, nor changes its `*_rdata`.
- R9: Reset (`rst_n`=0 at a clock edge) clears both `*_rdata` outputs and `collide` to 0 and leaves the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the output registers |
| cfg_block_b | input | 1 | Collision priority: 1 drops B's write, 0 drops A's write |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read-only (0) |
| a_mode | input | 1 | Port A read-during-write: 0 old data, 1 new data |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read-only (0) |
| b_mode | input | 1 | Port B read-during-write: 0 old data, 1 new data |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered read data |
| collide | output | 1 | One-cycle flag after a same-address double write |

## Verification
Directed cycles first put both ports on one address, once with each priority setting. Comparing `collide` and a later read-back shows whether the right write was kept, and whether the flag is raised only then. A double write to two different addresses, read back afterwards, separates true parallel update from a write that is delayed or serialised. Read-during-write is tried with each mode against the port's own write, against the other port's write and against a blocked write. This tells the old value, the forwarded value and the winner's value apart. A long random phase then confines the addresses to eight words so that clashes, cross-port hits and idle cycles mix freely, with modes and priority changing between cycles.

// File: rtl/twinport_pkg.sv
// Shared types for the twin-port RAM.
package twinport_pkg;
    // Read-during-write selection for one port.
    typedef enum logic {
        RDW_OLD = 1'b0,
        RDW_NEW = 1'b1
    } rdw_mode_e;

    // Index of each port in the per-port arrays.
    localparam int PORT_A = 0;
    localparam int PORT_B = 1;
    localparam int NUM_PORTS = 2;
endpackage

// File: rtl/tp_collide.sv
// Write-collision arbiter.
// Compares the two write requests and drops one write when both target the same word.
// Assumes cfg_block_b is held steady during traffic. The registered collide flag
// is cleared by the synchronous active-low reset.
module tp_collide #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_block_b,
    input  logic          a_req_wr,
    input  logic          b_req_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [AW-1:0] b_addr,
    output logic          a_wr_ok,
    output logic          b_wr_ok,
    output logic          clash,
    output logic          collide_q
);
    // Detect a double write and choose which port loses it.
    always_comb begin
        clash   = a_req_wr && b_req_wr && (a_addr == b_addr);
        a_wr_ok = a_req_wr && !(clash && !cfg_block_b);
        b_wr_ok = b_req_wr && !(clash && cfg_block_b);
    end

    // Register the collision event as a one-cycle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) collide_q <= 1'b0;
        else        collide_q <= clash;
    end
endmodule

// File: rtl/tp_store.sv
// Storage array with two write ports and two asynchronous read taps.
// Has no reset and no initial contents. Assumes the arbiter never allows
// two writes to one word in the same cycle.
module tp_store #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          a_wr,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          b_wr,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] a_old,
    output logic [DW-1:0] b_old
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Apply the writes that the arbiter granted.
    always_ff @(posedge clk) begin
        if (a_wr) mem[a_addr] <= a_wdata;
        if (b_wr) mem[b_addr] <= b_wdata;
    end

    // Present the pre-write content at each port address.
    always_comb begin
        a_old = mem[a_addr];
        b_old = mem[b_addr];
    end
endmodule

// File: rtl/tp_rdmux.sv
// Per-port read path.
// Picks old or forwarded new data according to the port's mode and registers it.
// Assumes own_wr and oth_wr are post-arbitration grants, so at most one of them
// hits a given address. The output holds while the port is disabled.
module tp_rdmux #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mode,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] old_word,
    input  logic          own_wr,
    input  logic [DW-1:0] own_wdata,
    input  logic          oth_wr,
    input  logic [AW-1:0] oth_addr,
    input  logic [DW-1:0] oth_wdata,
    output logic [DW-1:0] rdata_q
);
    import twinport_pkg::*;

    rdw_mode_e     mode_e;
    logic [DW-1:0] new_word;
    logic [DW-1:0] pick;

    // Form the post-write value of the addressed word and select by mode.
    always_comb begin
        mode_e = rdw_mode_e'(mode);
        if (own_wr)                           new_word = own_wdata;
        else if (oth_wr && oth_addr == addr)  new_word = oth_wdata;
        else                                  new_word = old_word;
        pick = (mode_e == RDW_NEW) ? new_word : old_word;
    end

    // Register the read result; hold when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (en) rdata_q <= pick;
    end
endmodule

// File: rtl/twinport_ram.sv
// Top level of the twin-port RAM with collision arbitration.
// Both ports share clk. Read data is registered (one-cycle latency).
// Memory contents are not reset; rst_n (synchronous, active low) clears
// only the read registers and the collision flag.
module twinport_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_block_b,
    input  logic          a_en,
    input  logic          a_we,
    input  logic          a_mode,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic          b_mode,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          collide
);
    import twinport_pkg::*;

    logic a_wr_ok, b_wr_ok, clash;
    logic [DW-1:0] a_old, b_old;

    // Per-port views used by the generated read paths.
    logic          en_v    [NUM_PORTS];
    logic          mode_v  [NUM_PORTS];
    logic [AW-1:0] addr_v  [NUM_PORTS];
    logic [DW-1:0] wdat_v  [NUM_PORTS];
    logic [DW-1:0] old_v   [NUM_PORTS];
    logic          wr_v    [NUM_PORTS];
    logic [DW-1:0] rdat_v  [NUM_PORTS];

    // Gather the port signals into arrays.
    always_comb begin
        en_v[PORT_A]   = a_en;    en_v[PORT_B]   = b_en;
        mode_v[PORT_A] = a_mode;  mode_v[PORT_B] = b_mode;
        addr_v[PORT_A] = a_addr;  addr_v[PORT_B] = b_addr;
        wdat_v[PORT_A] = a_wdata; wdat_v[PORT_B] = b_wdata;
        old_v[PORT_A]  = a_old;   old_v[PORT_B]  = b_old;
        wr_v[PORT_A]   = a_wr_ok; wr_v[PORT_B]   = b_wr_ok;
    end

    tp_collide #(.AW(AW)) u_collide (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_block_b (cfg_block_b),
        .a_req_wr    (a_en && a_we),
        .b_req_wr    (b_en && b_we),
        .a_addr      (a_addr),
        .b_addr      (b_addr),
        .a_wr_ok     (a_wr_ok),
        .b_wr_ok     (b_wr_ok),
        .clash       (clash),
        .collide_q   (collide)
    );

    tp_store #(.AW(AW), .DW(DW)) u_store (
        .clk     (clk),
        .a_wr    (a_wr_ok),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .b_wr    (b_wr_ok),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .a_old   (a_old),
        .b_old   (b_old)
    );

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_rd
        localparam int OTH = NUM_PORTS - 1 - gi;
        tp_rdmux #(.AW(AW), .DW(DW)) u_rdmux (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en_v[gi]),
            .mode      (mode_v[gi]),
            .addr      (addr_v[gi]),
            .old_word  (old_v[gi]),
            .own_wr    (wr_v[gi]),
            .own_wdata (wdat_v[gi]),
            .oth_wr    (wr_v[OTH]),
            .oth_addr  (addr_v[OTH]),
            .oth_wdata (wdat_v[OTH]),
            .rdata_q   (rdat_v[gi])
        );
    end

    assign a_rdata = rdat_v[PORT_A];
    assign b_rdata = rdat_v[PORT_B];
endmodule

// File: rtl/twinport_ram_chk.sv
// Property checker for twinport_ram, attached by bind below.
// Observes the ports and the arbiter grants; it drives nothing.
module twinport_ram_chk #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_block_b,
    input logic          a_en,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic          b_en,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] a_rdata,
    input logic [DW-1:0] b_rdata,
    input logic          a_wr_ok,
    input logic          b_wr_ok,
    input logic          collide
);
    logic dbl_same, dbl_diff;
    assign dbl_same = a_en && a_we && b_en && b_we && (a_addr == b_addr);
    assign dbl_diff = a_en && a_we && b_en && b_we && (a_addr != b_addr);

    p_one_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_same |-> $countones({a_wr_ok, b_wr_ok}) == 1);
    p_block_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_same && cfg_block_b) |-> (a_wr_ok && !b_wr_ok));
    p_block_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_same && !cfg_block_b) |-> (b_wr_ok && !a_wr_ok));
    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_same |=> collide);
    p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dbl_same |=> !collide);
    p_both_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_diff |-> (a_wr_ok && b_wr_ok));
    p_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> $stable(a_rdata));
    p_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_rdata));
    p_idle_nowr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_en |-> !a_wr_ok) and (!b_en |-> !b_wr_ok));
endmodule

bind twinport_ram twinport_ram_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_block_b (cfg_block_b),
    .a_en        (a_en),
    .a_we        (a_we),
    .a_addr      (a_addr),
    .b_en        (b_en),
    .b_we        (b_we),
    .b_addr      (b_addr),
    .a_rdata     (a_rdata),
    .b_rdata     (b_rdata),
    .a_wr_ok     (a_wr_ok),
    .b_wr_ok     (b_wr_ok),
    .collide     (collide)
);

// File: tb/test_twinport_ram.sv
// Bench for twinport_ram: behavioural reference model compared every cycle.
module test_twinport_ram;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam time TCK = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_block_b = 1'b0;
    logic          a_en = 0, a_we = 0, a_mode = 0;
    logic [AW-1:0] a_addr = '0;
    logic [DW-1:0] a_wdata = '0;
    logic [DW-1:0] a_rdata;
    logic          b_en = 0, b_we = 0, b_mode = 0;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_wdata = '0;
    logic [DW-1:0] b_rdata;
    logic          collide;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state.
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] exp_a = '0, exp_b = '0;
    bit            known_a = 1, known_b = 1;
    bit            exp_col = 0;

    always #(TCK/2) clk = ~clk;

    twinport_ram #(.AW(AW), .DW(DW)) i_twinport_ram (
        .clk(clk), .rst_n(rst_n), .cfg_block_b(cfg_block_b),
        .a_en(a_en), .a_we(a_we), .a_mode(a_mode), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_mode(b_mode), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .collide(collide)
    );

    task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: inputs are already driven; model then compare at negedge.
    task automatic step(string req);
        bit aw, bw, clash;
        logic [DW-1:0] old_a, old_b, new_a, new_b;
        bit ka, kb, kna, knb;
        aw = a_en && a_we;
        bw = b_en && b_we;
        clash = aw && bw && (a_addr == b_addr);
        if (clash) begin
            if (cfg_block_b) bw = 0; else aw = 0;
        end
        ka = ref_mem.exists(int'(a_addr)); old_a = ka ? ref_mem[int'(a_addr)] : '0;
        kb = ref_mem.exists(int'(b_addr)); old_b = kb ? ref_mem[int'(b_addr)] : '0;
        new_a = old_a; kna = ka;
        if (aw) begin new_a = a_wdata; kna = 1; end
        else if (bw && b_addr == a_addr) begin new_a = b_wdata; kna = 1; end
        new_b = old_b; knb = kb;
        if (bw) begin new_b = b_wdata; knb = 1; end
        else if (aw && a_addr == b_addr) begin new_b = a_wdata; knb = 1; end
        if (a_en) begin exp_a = a_mode ? new_a : old_a; known_a = a_mode ? kna : ka; end
        if (b_en) begin exp_b = b_mode ? new_b : old_b; known_b = b_mode ? knb : kb; end
        if (aw) ref_mem[int'(a_addr)] = a_wdata;
        if (bw) ref_mem[int'(b_addr)] = b_wdata;
        exp_col = clash;
        @(posedge clk);
        @(negedge clk);
        if (known_a) check(req, "a_rdata", a_rdata, exp_a);
        if (known_b) check(req, "b_rdata", b_rdata, exp_b);
        check("R4", "collide", {{(DW-1){1'b0}}, collide}, {{(DW-1){1'b0}}, exp_col});
    endtask

    task automatic drive_a(bit en, bit we, bit mode, int addr, int data);
        a_en = en; a_we = we; a_mode = mode; a_addr = AW'(addr); a_wdata = DW'(data);
    endtask
    task automatic drive_b(bit en, bit we, bit mode, int addr, int data);
        b_en = en; b_we = we; b_mode = mode; b_addr = AW'(addr); b_wdata = DW'(data);
    endtask
    task automatic idle();
        drive_a(0, 0, 0, 0, 0); drive_b(0, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(TCK * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R9 reset state.
        check("R9", "a_rdata reset", a_rdata, '0);
        check("R9", "b_rdata reset", b_rdata, '0);
        check("R9", "collide reset", {{(DW-1){1'b0}}, collide}, '0);
        rst_n = 1'b1;

        // R5: parallel writes to distinct words, then read back (R1).
        drive_a(1, 1, 0, 10, 'h1111); drive_b(1, 1, 0, 20, 'h2222); step("R5");
        drive_a(1, 0, 0, 20, 0); drive_b(1, 0, 0, 10, 0); step("R5");
        drive_a(1, 0, 1, 10, 0); drive_b(1, 0, 1, 20, 0); step("R1");

        // R3 / R2: same-word double write, B blocked.
        cfg_block_b = 1;
        drive_a(1, 1, 0, 30, 'hAAAA); drive_b(1, 1, 0, 30, 'hBBBB); step("R3");
        drive_a(1, 0, 0, 30, 0); drive_b(1, 0, 0, 30, 0); step("R2");
        // A blocked.
        cfg_block_b = 0;
        drive_a(1, 1, 1, 31, 'hC0C0); drive_b(1, 1, 1, 31, 'hD0D0); step("R7");
        drive_a(1, 0, 0, 31, 0); drive_b(1, 0, 0, 31, 0); step("R3");

        // R6: old-data mode on own write and on other port's write.
        drive_a(1, 1, 0, 10, 'h5555); drive_b(1, 0, 0, 10, 0); step("R6");
        // R7: new-data mode sees other port's write.
        drive_a(1, 1, 0, 20, 'h6666); drive_b(1, 0, 1, 20, 0); step("R7");
        drive_a(1, 0, 1, 40, 0); drive_b(1, 1, 1, 40, 'h7777); step("R7");

        // R8: disabled port with we=1 writes nothing, output holds.
        drive_a(0, 1, 0, 10, 'hDEAD); drive_b(1, 0, 0, 20, 0); step("R8");
        drive_a(1, 0, 0, 10, 0); drive_b(0, 1, 0, 20, 'hBEEF); step("R8");
        drive_a(1, 0, 0, 20, 0); idle(); a_en = 1; a_addr = 20; step("R8");

        // R9: reset clears outputs, keeps contents.
        idle();
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9", "a_rdata after reset", a_rdata, '0);
        check("R9", "b_rdata after reset", b_rdata, '0);
        exp_a = '0; exp_b = '0; known_a = 1; known_b = 1;
        rst_n = 1'b1;
        drive_a(1, 0, 0, 10, 0); drive_b(1, 0, 0, 30, 0); step("R9");

        // Random mix on eight words.
        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0) cfg_block_b = $urandom_range(0, 1);
            drive_a($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 7), $urandom_range(0, 65535));
            drive_b($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 7), $urandom_range(0, 65535));
            step("R1");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule